// File: doc/BRIEF.md
# Count-Zeros Unit (leading or trailing, 32 or 64 bit)

This purely combinational unit reports how many zero bits precede the first set bit of an operand. The scan can start at the most significant end (leading zeros) or the least significant end (trailing zeros). It works either on the whole 64-bit operand or on its low half. The unit sits in an execute stage beside the logical unit. It has no clock and no state, so the count settles within the same cycle as the inputs.

The operand is first shaped into one scan field. Trailing counts reverse the examined bits, and half-width counts move the low half to the top of the field with zeros below it. The field then goes through a radix-4 priority tree. Every node uses the same 4-bit encoder. Each node above the leaves picks the winning child's partial index with a 4:1 selection. The encoders run whatever the operand is. Only the final assignment looks at whether any bit was found, and an empty field yields the examined width.

Top module: `clz_unit`

## Requirements
- R1: With from_lsb_i=0 and half_width_i=0, zero_count_o equals the number of zero bits above the highest set bit of operand_i[63:0].
- R2: With from_lsb_i=1 and half_width_i=0, zero_count_o equals the number of zero bits below the lowest set bit of operand_i[63:0].
- R3: With from_lsb_i=0 and half_width_i=1, zero_count_o counts zeros downward from bit 31 to the highest set bit within operand_i[31:0].
- R4: With from_lsb_i=1 and half_width_i=1, zero_count_o counts zeros upward from bit 0 to the lowest set bit within operand_i[31:0].
- R5: When the examined field has no set bit, zero_count_o is 64 (half_width_i=0) or 32 (half_width_i=1).
- R6: With half_width_i=1, operand_i[63:32] has no effect on zero_count_o in either direction.
- R7: zero_count_o never exceeds the examined width. It is 7 bits wide, and bit 6 is set only for a 64-bit count of 64.
- R8: A single set bit at any position gives the exact count for that position, in all four modes, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 64 | Value whose zero bits are counted |
| from_lsb_i | input | 1 | 1 = count trailing zeros, 0 = count leading zeros |
| half_width_i | input | 1 | 1 = examine only bits 31:0, 0 = examine all 64 bits |
| zero_count_o | output | 7 | Number of zeros before the first set bit, or the width if none |

## Verification
Each of the four modes is tried with a one-hot walk across all bit positions. A wrong leaf encoding, a swapped 4:1 selection or a broken reversal each misplaces a specific position, so the walk shows which one is at fault. Operands that are all ones, alternating, or filled with random bits below a chosen leading one separate true priority behaviour from logic that only works for one-hot inputs. The half-width modes are driven with garbage in bits 63:32 and with an all-zero low half. These cases show whether the upper half leaks into the scan and whether the empty-field result picks 32 rather than 64.

// File: rtl/clz_pkg.sv
package clz_pkg;

  typedef struct packed {
    logic       hit;
    logic [1:0] pos;
  } pe4_t;

  // Priority encode four bits, bit 3 being the most significant.
  function automatic pe4_t pe4(input logic [3:0] b);
    pe4_t r;
    r.hit = |b;
    if (b[3])      r.pos = 2'd0;
    else if (b[2]) r.pos = 2'd1;
    else if (b[1]) r.pos = 2'd2;
    else           r.pos = 2'd3;
    return r;
  endfunction

  function automatic int lvl_nodes(input int w, input int l);
    return w >> (2 * (l + 1));
  endfunction

  function automatic int vld_base(input int w, input int l);
    int s;
    s = 0;
    for (int j = 0; j < l; j++) s += lvl_nodes(w, j);
    return s;
  endfunction

  function automatic int idx_base(input int w, input int l);
    int s;
    s = 0;
    for (int j = 0; j < l; j++) s += lvl_nodes(w, j) * 2 * (j + 1);
    return s;
  endfunction

endpackage

// File: rtl/clz_operand_prep.sv
module clz_operand_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0] operand_i,
  input  logic         from_lsb_i,
  input  logic         half_width_i,
  output logic [W-1:0] field_o
);
  localparam int HW = W / 2;

  logic [W-1:0]  rev_full;
  logic [HW-1:0] rev_lo;
  logic [W-1:0]  full_sel;
  logic [HW-1:0] lo_sel;

  always_comb begin
    for (int i = 0; i < W; i++)  rev_full[i] = operand_i[W-1-i];
    for (int i = 0; i < HW; i++) rev_lo[i]   = operand_i[HW-1-i];
  end

  always_comb begin
    full_sel = from_lsb_i ? rev_full : operand_i;
    lo_sel   = from_lsb_i ? rev_lo   : operand_i[HW-1:0];
    field_o  = half_width_i ? {lo_sel, {HW{1'b0}}} : full_sel;
  end
endmodule

// File: rtl/clz_leaf_level.sv
module clz_leaf_level #(
  parameter int W = 64,
  localparam int N = W / 4
) (
  input  logic [W-1:0]   data_i,
  output logic [N-1:0]   vld_o,
  output logic [N*2-1:0] idx_o
);
  import clz_pkg::*;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      pe4_t e;
      e = pe4(data_i[W-1-4*k -: 4]);
      vld_o[k]        = e.hit;
      idx_o[k*2 +: 2] = e.pos;
    end
  end
endmodule

// File: rtl/clz_node_level.sv
module clz_node_level #(
  parameter int CHILDREN = 16,
  parameter int CIW      = 2,
  localparam int N  = CHILDREN / 4,
  localparam int OW = CIW + 2
) (
  input  logic [CHILDREN-1:0]     child_vld_i,
  input  logic [CHILDREN*CIW-1:0] child_idx_i,
  output logic [N-1:0]            vld_o,
  output logic [N*OW-1:0]         idx_o
);
  import clz_pkg::*;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      pe4_t e;
      int   c;
      e = pe4({child_vld_i[4*k], child_vld_i[4*k+1],
               child_vld_i[4*k+2], child_vld_i[4*k+3]});
      c = 4 * k + int'(e.pos);
      vld_o[k]          = e.hit;
      idx_o[k*OW +: OW] = {e.pos, child_idx_i[c*CIW +: CIW]};
    end
  end
endmodule

// File: rtl/clz_unit.sv
module clz_unit #(
  parameter int W = 64
) (
  input  logic [W-1:0]           operand_i,
  input  logic                   from_lsb_i,
  input  logic                   half_width_i,
  output logic [$clog2(W):0]     zero_count_o
);
  import clz_pkg::*;

  localparam int HW      = W / 2;
  localparam int PW      = $clog2(W);
  localparam int CNT_W   = PW + 1;
  localparam int LVLS    = PW / 2;
  localparam int VLD_TOT = vld_base(W, LVLS);
  localparam int IDX_TOT = idx_base(W, LVLS);

  logic [W-1:0]       field;
  logic [VLD_TOT-1:0] vld_bus;
  logic [IDX_TOT-1:0] idx_bus;
  logic               top_hit;
  logic [PW-1:0]      top_idx;

  clz_operand_prep #(.W(W)) u_prep (
    .operand_i    (operand_i),
    .from_lsb_i   (from_lsb_i),
    .half_width_i (half_width_i),
    .field_o      (field)
  );

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int N  = lvl_nodes(W, l);
    localparam int IW = 2 * (l + 1);
    localparam int VB = vld_base(W, l);
    localparam int IB = idx_base(W, l);
    if (l == 0) begin : g_leaf
      clz_leaf_level #(.W(W)) u_leaf (
        .data_i (field),
        .vld_o  (vld_bus[VB +: N]),
        .idx_o  (idx_bus[IB +: N*2])
      );
    end else begin : g_node
      localparam int PVB = vld_base(W, l - 1);
      localparam int PIB = idx_base(W, l - 1);
      clz_node_level #(.CHILDREN(N*4), .CIW(IW-2)) u_node (
        .child_vld_i (vld_bus[PVB +: N*4]),
        .child_idx_i (idx_bus[PIB +: N*4*(IW-2)]),
        .vld_o       (vld_bus[VB +: N]),
        .idx_o       (idx_bus[IB +: N*IW])
      );
    end
  end

  assign top_hit = vld_bus[VLD_TOT-1];
  assign top_idx = idx_bus[IDX_TOT-1 -: PW];

  // Zero test only chooses what reaches the output.
  always_comb begin
    if (top_hit)           zero_count_o = CNT_W'(top_idx);
    else if (half_width_i) zero_count_o = CNT_W'(HW);
    else                   zero_count_o = CNT_W'(W);
  end
endmodule

// File: rtl/clz_unit_checker.sv
module clz_unit_checker #(
  parameter int W = 64
) (
  input logic [W-1:0]       operand_i,
  input logic               from_lsb_i,
  input logic               half_width_i,
  input logic [$clog2(W):0] zero_count_o
);
  localparam int HW = W / 2;

  always_comb begin
    if (!$isunknown({operand_i, from_lsb_i, half_width_i, zero_count_o})) begin
      int lim;
      int cnt;
      logic [W-1:0] exam;
      lim  = half_width_i ? HW : W;
      cnt  = int'(zero_count_o);
      exam = half_width_i ? {{HW{1'b0}}, operand_i[HW-1:0]} : operand_i;
      p_bound_r7: assert (cnt <= lim)
        else $error("count %0d above width %0d", cnt, lim);
      if (cnt < lim) begin
        if (!from_lsb_i) begin
          p_lead_hit_r1: assert (exam[lim-1-cnt])
            else $error("leading count does not land on a one");
          p_lead_clear_r3: assert ((exam >> (lim - cnt)) == '0)
            else $error("set bit skipped above leading count");
        end else begin
          p_trail_hit_r2: assert (exam[cnt])
            else $error("trailing count does not land on a one");
          p_trail_clear_r4: assert ((exam & ((W'(1) << cnt) - W'(1))) == '0)
            else $error("set bit skipped below trailing count");
        end
      end else begin
        p_empty_r5: assert (exam == '0)
          else $error("full-width count with a set bit present");
      end
    end
  end
endmodule

bind clz_unit clz_unit_checker #(.W(W)) u_chk (
  .operand_i    (operand_i),
  .from_lsb_i   (from_lsb_i),
  .half_width_i (half_width_i),
  .zero_count_o (zero_count_o)
);

// File: tb/clz_unit_test.sv
module clz_unit_test;
  localparam int W = 64;

  typedef struct {
    logic [6:0] exp;
    string      tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [63:0] operand;
  logic        from_lsb;
  logic        half;
  logic [6:0]  count;

  item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  clz_unit #(.W(W)) uut (
    .operand_i    (operand),
    .from_lsb_i   (from_lsb),
    .half_width_i (half),
    .zero_count_o (count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [6:0] model(logic [63:0] op, logic tr, logic hf);
    int w;
    int n;
    w = hf ? 32 : 64;
    n = 0;
    if (tr) begin
      for (int i = 0; i < w; i++) begin
        if (op[i]) break;
        n++;
      end
    end else begin
      for (int i = w - 1; i >= 0; i--) begin
        if (op[i]) break;
        n++;
      end
    end
    return 7'(n);
  endfunction

  task automatic drive(logic [63:0] op, logic tr, logic hf, string tag);
    item_t it;
    @(posedge clk);
    operand  = op;
    from_lsb = tr;
    half     = hf;
    it.exp   = model(op, tr, hf);
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive_exp(logic [63:0] op, logic tr, logic hf, logic [6:0] e, string tag);
    item_t it;
    @(posedge clk);
    operand  = op;
    from_lsb = tr;
    half     = hf;
    it.exp   = e;
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: one comparison per driven item, half a cycle after drive.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (count !== it.exp) begin
        errors++;
        $display("FAIL %s op=%h lsb=%b half=%b got=%0d exp=%0d",
                 it.tag, operand, from_lsb, half, count, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    operand  = '0;
    from_lsb = 1'b0;
    half     = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R5 state after reset: zero operand, 64-bit leading
    drive_exp(64'h0, 1'b0, 1'b0, 7'd64, "R5 reset zero 64");
    drive_exp(64'h0, 1'b1, 1'b0, 7'd64, "R5 zero trailing 64");
    drive_exp(64'h0, 1'b0, 1'b1, 7'd32, "R5 zero leading 32");
    drive_exp(64'hFFFF_FFFF_0000_0000, 1'b1, 1'b1, 7'd32, "R5 R6 empty low half");

    // R8 one-hot walk in all four modes
    for (int p = 0; p < 64; p++) begin
      drive_exp(64'h1 << p, 1'b0, 1'b0, 7'(63 - p), "R8 R1 onehot lead64");
      drive_exp(64'h1 << p, 1'b1, 1'b0, 7'(p),      "R8 R2 onehot trail64");
    end
    for (int p = 0; p < 32; p++) begin
      drive_exp(64'h1 << p, 1'b0, 1'b1, 7'(31 - p), "R8 R3 onehot lead32");
      drive_exp(64'h1 << p, 1'b1, 1'b1, 7'(p),      "R8 R4 onehot trail32");
    end

    // R1 R2 dense patterns
    drive_exp(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 7'd0, "R1 all ones");
    drive_exp(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 7'd0, "R2 all ones");
    drive_exp(64'h5555_5555_5555_5555, 1'b0, 1'b0, 7'd1, "R1 alternating");
    drive_exp(64'hAAAA_AAAA_AAAA_AAAA, 1'b1, 1'b0, 7'd1, "R2 alternating");
    drive_exp(64'h0000_0001_8000_0000, 1'b0, 1'b0, 7'd31, "R1 mid straddle");
    drive_exp(64'h0000_0001_8000_0000, 1'b1, 1'b0, 7'd31, "R2 mid straddle");

    // R6 garbage in the upper half must not leak
    drive_exp(64'hFFFF_FFFF_0000_8000, 1'b0, 1'b1, 7'd16, "R6 R3 upper garbage");
    drive_exp(64'hDEAD_BEEF_0001_0000, 1'b1, 1'b1, 7'd16, "R6 R4 upper garbage");
    drive_exp(64'h8000_0000_0000_0001, 1'b0, 1'b1, 7'd31, "R6 R3 bit63 ignored");
    drive_exp(64'h0000_0001_8000_0000, 1'b1, 1'b1, 7'd31, "R6 R4 bit32 ignored");

    // R7 width: only the 64-bit empty case sets bit 6
    drive_exp(64'h1, 1'b0, 1'b0, 7'd63, "R7 max nonempty 64");
    drive_exp(64'h8000_0000_0000_0000, 1'b1, 1'b0, 7'd63, "R7 max nonempty trail");

    // Random operands with a forced leading one, all modes
    for (int r = 0; r < 200; r++) begin
      logic [63:0] v;
      int sh;
      v  = {$urandom, $urandom};
      sh = r % 64;
      v  = (v | 64'h8000_0000_0000_0000) >> sh;
      drive(v, 1'b0, 1'b0, "R1 random");
      drive(v, 1'b1, 1'b0, "R2 random");
      drive(v, 1'b0, 1'b1, "R3 random");
      drive(v, 1'b1, 1'b1, "R4 random");
    end

    while (sb_q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule